// File: doc/BRIEF.md
# Rank and DRAM Coordinate Decoder

This block turns a channel-local physical address into DRAM coordinates: the DIMM and rank on the channel, the address seen by that rank once rank interleaving is removed, and the row, column, bank address and bank group. A small table of rank ranges, each with its own interleave factor, is programmed through a write port. For each range there is one interleave word per way, and that word names the target channel-rank and an offset to remove. Each request also carries the page-policy and bank-hashing settings of the DIMM.

A request is one cycle of `req_valid_i` with the address and configuration. Two cycles later `done_o` pulses with the coordinates. If no range covers the address, `err_o` is raised instead. Row and column bits are collected from scattered address bits. Which bits are used depends on close-page or open-page policy and on fine-grain bank mode. The two bank indices can be hashed with higher address bits.

Top module: `rank_coord_dec`

## Requirements
- R1: Range entry word: bit 31 = valid; bits 11:1 = L, giving the upper bound L*2^29 + (2^29-1); bits 29:28 = log2 of the way count (1, 2, 4 or 8). A write with wr_addr_i[5]=0 loads entry wr_addr_i[1:0]. Entries are tried in ascending index order and the first valid entry that covers the address is used.
- R2: The lower bound of entry 0 is 0. The lower bound of entry e>0 is the upper bound of entry e-1, inclusive, whether or not entry e-1 is valid.
- R3: The design samples the address and configuration inputs with req_valid_i. done_o is high exactly two clock cycles later, for one cycle for each request.
- R4: If no valid entry covers the address, err_o is high together with done_o and every coordinate output is zero. Whenever done_o is low, err_o and all coordinate outputs are zero.
- R5: The interleave shift s is 6 in close-page mode and 13 in open-page mode. With q = addr >> s and w ways, the way index is q mod w, and the pre-offset rank address is ((q / w) << s) with the low s address bits kept.
- R6: A write with wr_addr_i[5]=1 loads the interleave word for way wr_addr_i[4:2] of entry wr_addr_i[1:0]. In that word, bits 19:16 are the channel-rank, and bits 15:2 times 2^26 are an offset. The offset is subtracted modulo 2^ADDR_W to give rank_addr_o. dimm_o is channel-rank[3:2] and rank_o is channel-rank[1:0].
- R7: In close-page mode, row bit i comes from rank-address bit i of the list 15,16,17,18,20,21,22,28,10,11,12,13,29,30,31,32,33. Column bits 0..9 come from 3,4,5,14,19,23,24,25,26,27. col_o[10] is 1.
- R8: In open-page mode, row bits come from 14,15,16,20,28,21,22,23,24,25,26,27,29,30,31,32,33 and column bits 0..9 from 3..12. col_o[10] is 0.
- R9: In open-page mode with fine-grain set, column bits come from 3,4,5,7,8,9,10,11,12,13, and the bank-group LSB is bit 6 instead of bit 13.
- R10: Without hashing, the bank address is {bit 9, bit 8} in close-page mode and {bit 19, bit 18} in open-page mode. The bank group is {bit 7, bit 6} in close-page mode and {bit 17, bit 13 or bit 6} in open-page mode.
- R11: With bank XOR set, the bank address is XORed with {bit 28, bit 22} in close-page mode or {bit 23, bit 22} in open-page mode. The bank group is XORed with {bit 21, bit 20} in both modes.
- R12: Row bits at and above row_bits_i (12..17) are zero. Gathered column bits at and above col_bits_i (10) are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | 6 | Table select [5], way [4:2], entry [1:0] |
| wr_data_i | input | 32 | Table write data |
| req_valid_i | input | 1 | Decode request |
| chan_addr_i | input | ADDR_W | Channel-local address |
| close_page_i | input | 1 | Close-page policy |
| fine_grain_i | input | 1 | Fine-grain bank mode |
| bank_xor_i | input | 1 | Bank index hashing enable |
| row_bits_i | input | 5 | Row bit count |
| col_bits_i | input | 4 | Column bit count |
| done_o | output | 1 | Result valid |
| err_o | output | 1 | No range matched |
| dimm_o | output | 2 | DIMM on channel |
| rank_o | output | 2 | Rank within DIMM |
| rank_addr_o | output | ADDR_W | Rank address |
| row_o | output | 17 | Row |
| col_o | output | 11 | Column, bit 10 auto-precharge |
| bank_o | output | 2 | Bank address |
| bank_group_o | output | 2 | Bank group |

## Verification
The hardest cases to reach are the range boundaries. The lower bound is inclusive and is inherited from an entry that may be invalid, so a single address can sit in the gap below an invalid entry or on a limit that two neighbours share. The bench programs an invalid entry between two valid ones and decodes addresses exactly on, just below and just above each limit. The bench also walks the way index through every way of a four-way range, in both shift positions, so that each interleave word, with its own offset and channel-rank, is selected. A pseudo-random sweep then mixes page policy, hashing and row counts against a model built from the requirements.

// File: rtl/rdec_pkg.sv
package rdec_pkg;
  localparam int DATA_W      = 32;
  localparam int VLD_BIT     = 31;
  localparam int WAYS_LSB    = 28;
  localparam int WAYS_W      = 2;
  localparam int LIM_FLD_LSB = 1;
  localparam int LIM_W       = 11;
  localparam int LIM_LSB     = 29;
  localparam int CR_LSB      = 16;
  localparam int CR_W        = 4;
  localparam int OFF_FLD_LSB = 2;
  localparam int OFF_W       = 14;
  localparam int OFF_LSB     = 26;
  localparam int SH_CLOSE    = 6;
  localparam int SH_OPEN     = 13;
  localparam int ROW_W       = 17;
  localparam int COLG_W      = 10;
  localparam int COL_W       = COLG_W + 1;
  localparam int RB_W        = 5;
  localparam int CB_W        = 4;

  // address bit feeding row/column bit i, per page policy
  localparam int ROW_CLOSE [ROW_W] = '{15, 16, 17, 18, 20, 21, 22, 28, 10, 11, 12, 13, 29, 30, 31, 32, 33};
  localparam int ROW_OPEN  [ROW_W] = '{14, 15, 16, 20, 28, 21, 22, 23, 24, 25, 26, 27, 29, 30, 31, 32, 33};
  localparam int COL_CLOSE [COLG_W] = '{3, 4, 5, 14, 19, 23, 24, 25, 26, 27};
  localparam int COL_OPEN  [COLG_W] = '{3, 4, 5, 6, 7, 8, 9, 10, 11, 12};
  localparam int COL_FINE  [COLG_W] = '{3, 4, 5, 7, 8, 9, 10, 11, 12, 13};
endpackage

// File: rtl/rdec_regs.sv
module rdec_regs import rdec_pkg::*; #(
  parameter int N_RANGE = 4,
  parameter int N_WAY   = 8,
  localparam int EW     = $clog2(N_RANGE),
  localparam int WW     = $clog2(N_WAY),
  localparam int WR_AW  = 1 + WW + EW
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic                                      wr_en_i,
  input  logic [WR_AW-1:0]                          wr_addr_i,
  input  logic [DATA_W-1:0]                         wr_data_i,
  output logic [N_RANGE-1:0]                        rng_vld_o,
  output logic [N_RANGE-1:0][WAYS_W-1:0]            rng_wlog_o,
  output logic [N_RANGE-1:0][LIM_W-1:0]             rng_lim_o,
  output logic [N_WAY-1:0][N_RANGE-1:0][CR_W-1:0]   ilv_cr_o,
  output logic [N_WAY-1:0][N_RANGE-1:0][OFF_W-1:0]  ilv_off_o
);
  logic          sel_ilv;
  logic [WW-1:0] wr_way;
  logic [EW-1:0] wr_ent;
  logic          unused_data;

  assign sel_ilv     = wr_addr_i[WR_AW-1];
  assign wr_way      = wr_addr_i[EW +: WW];
  assign wr_ent      = wr_addr_i[EW-1:0];
  assign unused_data = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rng_vld_o  <= '0;
      rng_wlog_o <= '0;
      rng_lim_o  <= '0;
    end else if (wr_en_i && !sel_ilv) begin
      rng_vld_o[wr_ent]  <= wr_data_i[VLD_BIT];
      rng_wlog_o[wr_ent] <= wr_data_i[WAYS_LSB +: WAYS_W];
      rng_lim_o[wr_ent]  <= wr_data_i[LIM_FLD_LSB +: LIM_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ilv_cr_o  <= '0;
      ilv_off_o <= '0;
    end else if (wr_en_i && sel_ilv) begin
      ilv_cr_o[wr_way][wr_ent]  <= wr_data_i[CR_LSB +: CR_W];
      ilv_off_o[wr_way][wr_ent] <= wr_data_i[OFF_FLD_LSB +: OFF_W];
    end
  end
endmodule

// File: rtl/rdec_range.sv
module rdec_range import rdec_pkg::*; #(
  parameter int ADDR_W  = 40,
  parameter int N_RANGE = 4,
  localparam int EW     = $clog2(N_RANGE)
) (
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [N_RANGE-1:0]            rng_vld_i,
  input  logic [N_RANGE-1:0][WAYS_W-1:0] rng_wlog_i,
  input  logic [N_RANGE-1:0][LIM_W-1:0] rng_lim_i,
  output logic                          hit_o,
  output logic [EW-1:0]                 ent_o,
  output logic [WAYS_W-1:0]             wlog_o
);
  logic [N_RANGE-1:0][ADDR_W-1:0] lim;
  logic [N_RANGE-1:0][ADDR_W-1:0] lo;
  logic [N_RANGE-1:0]             hit;

  for (genvar e = 0; e < N_RANGE; e++) begin : g_ent
    assign lim[e] = ADDR_W'({rng_lim_i[e], {LIM_LSB{1'b1}}});
    if (e == 0) begin : g_first
      assign lo[e] = '0;
    end else begin : g_next
      // bound inherited even from an invalid predecessor
      assign lo[e] = lim[e-1];
    end
    assign hit[e] = rng_vld_i[e] && (addr_i >= lo[e]) && (addr_i <= lim[e]);
  end

  always_comb begin
    hit_o = 1'b0;
    ent_o = '0;
    for (int e = N_RANGE - 1; e >= 0; e--) begin
      if (hit[e]) begin
        hit_o = 1'b1;
        ent_o = EW'(e);
      end
    end
  end

  assign wlog_o = rng_wlog_i[ent_o];
endmodule

// File: rtl/rdec_map.sv
module rdec_map import rdec_pkg::*; #(
  parameter int ADDR_W = 40
) (
  input  logic [ADDR_W-1:0] ra_i,
  input  logic              close_i,
  input  logic              fine_i,
  input  logic              bxor_i,
  input  logic [RB_W-1:0]   row_bits_i,
  input  logic [CB_W-1:0]   col_bits_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic [1:0]        bank_o,
  output logic [1:0]        bg_o
);
  logic [ROW_W-1:0]  row_raw;
  logic [COLG_W-1:0] col_raw;
  logic [ROW_W-1:0]  row_mask;
  logic [COLG_W-1:0] col_mask;
  logic [1:0]        ba_base, ba_hash, bg_base, bg_hash;
  logic              unused_ra;

  assign unused_ra = ^ra_i;

  for (genvar i = 0; i < ROW_W; i++) begin : g_row
    assign row_raw[i] = close_i ? ra_i[ROW_CLOSE[i]] : ra_i[ROW_OPEN[i]];
  end

  for (genvar i = 0; i < COLG_W; i++) begin : g_col
    assign col_raw[i] = close_i ? ra_i[COL_CLOSE[i]] :
                        (fine_i ? ra_i[COL_FINE[i]] : ra_i[COL_OPEN[i]]);
  end

  assign row_mask = ~({ROW_W{1'b1}} << row_bits_i);
  assign col_mask = ~({COLG_W{1'b1}} << col_bits_i);
  assign row_o    = row_raw & row_mask;
  // top column bit is auto-precharge, tied to page policy
  assign col_o    = {close_i, col_raw & col_mask};

  always_comb begin
    if (close_i) begin
      ba_base = {ra_i[9], ra_i[8]};
      ba_hash = {ra_i[28], ra_i[22]};
      bg_base = {ra_i[7], ra_i[6]};
    end else begin
      ba_base = {ra_i[19], ra_i[18]};
      ba_hash = {ra_i[23], ra_i[22]};
      bg_base = {ra_i[17], fine_i ? ra_i[6] : ra_i[13]};
    end
    bg_hash = {ra_i[21], ra_i[20]};
  end

  assign bank_o = ba_base ^ (bxor_i ? ba_hash : 2'b00);
  assign bg_o   = bg_base ^ (bxor_i ? bg_hash : 2'b00);
endmodule

// File: rtl/rank_coord_dec.sv
module rank_coord_dec import rdec_pkg::*; #(
  parameter int ADDR_W  = 40,
  parameter int N_RANGE = 4,
  parameter int N_WAY   = 8,
  localparam int EW     = $clog2(N_RANGE),
  localparam int WW     = $clog2(N_WAY),
  localparam int WR_AW  = 1 + WW + EW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WR_AW-1:0]  wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] chan_addr_i,
  input  logic              close_page_i,
  input  logic              fine_grain_i,
  input  logic              bank_xor_i,
  input  logic [4:0]        row_bits_i,
  input  logic [3:0]        col_bits_i,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        dimm_o,
  output logic [1:0]        rank_o,
  output logic [ADDR_W-1:0] rank_addr_o,
  output logic [16:0]       row_o,
  output logic [10:0]       col_o,
  output logic [1:0]        bank_o,
  output logic [1:0]        bank_group_o
);
  logic [N_RANGE-1:0]                       rng_vld;
  logic [N_RANGE-1:0][WAYS_W-1:0]           rng_wlog;
  logic [N_RANGE-1:0][LIM_W-1:0]            rng_lim;
  logic [N_WAY-1:0][N_RANGE-1:0][CR_W-1:0]  ilv_cr;
  logic [N_WAY-1:0][N_RANGE-1:0][OFF_W-1:0] ilv_off;

  rdec_regs #(.N_RANGE(N_RANGE), .N_WAY(N_WAY)) regs_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rng_vld_o(rng_vld), .rng_wlog_o(rng_wlog), .rng_lim_o(rng_lim),
    .ilv_cr_o(ilv_cr), .ilv_off_o(ilv_off)
  );

  // stage 0: range match and interleave strip
  logic              hit0;
  logic [EW-1:0]     ent0;
  logic [WAYS_W-1:0] wlog0;
  logic [3:0]        sh0;
  logic [ADDR_W-1:0] q0, pre0;
  logic [WW-1:0]     idx0, way_mask0;

  rdec_range #(.ADDR_W(ADDR_W), .N_RANGE(N_RANGE)) range_i (
    .addr_i(chan_addr_i), .rng_vld_i(rng_vld), .rng_wlog_i(rng_wlog),
    .rng_lim_i(rng_lim), .hit_o(hit0), .ent_o(ent0), .wlog_o(wlog0)
  );

  assign sh0       = close_page_i ? 4'(SH_CLOSE) : 4'(SH_OPEN);
  assign q0        = chan_addr_i >> sh0;
  assign way_mask0 = WW'((4'd1 << wlog0) - 4'd1);
  assign idx0      = q0[WW-1:0] & way_mask0;
  assign pre0      = ((q0 >> wlog0) << sh0) | (chan_addr_i & ~({ADDR_W{1'b1}} << sh0));

  logic              s1_vld, s1_hit, s1_close, s1_fine, s1_xor;
  logic [EW-1:0]     s1_ent;
  logic [WW-1:0]     s1_idx;
  logic [ADDR_W-1:0] s1_pre;
  logic [RB_W-1:0]   s1_rowb;
  logic [CB_W-1:0]   s1_colb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld   <= 1'b0;
      s1_hit   <= 1'b0;
      s1_close <= 1'b0;
      s1_fine  <= 1'b0;
      s1_xor   <= 1'b0;
      s1_ent   <= '0;
      s1_idx   <= '0;
      s1_pre   <= '0;
      s1_rowb  <= '0;
      s1_colb  <= '0;
    end else begin
      s1_vld <= req_valid_i;
      if (req_valid_i) begin
        s1_hit   <= hit0;
        s1_close <= close_page_i;
        s1_fine  <= fine_grain_i;
        s1_xor   <= bank_xor_i;
        s1_ent   <= ent0;
        s1_idx   <= idx0;
        s1_pre   <= pre0;
        s1_rowb  <= row_bits_i;
        s1_colb  <= col_bits_i;
      end
    end
  end

  // stage 1: interleave word, offset removal, DRAM mapping
  logic [CR_W-1:0]   cr1;
  logic [ADDR_W-1:0] off1, ra1;
  logic [ROW_W-1:0]  row1;
  logic [COL_W-1:0]  col1;
  logic [1:0]        bank1, bg1;
  logic              emit1;

  assign cr1   = ilv_cr[s1_idx][s1_ent];
  assign off1  = ADDR_W'(ilv_off[s1_idx][s1_ent]) << OFF_LSB;
  assign ra1   = s1_pre - off1;
  assign emit1 = s1_vld && s1_hit;

  rdec_map #(.ADDR_W(ADDR_W)) map_i (
    .ra_i(ra1), .close_i(s1_close), .fine_i(s1_fine), .bxor_i(s1_xor),
    .row_bits_i(s1_rowb), .col_bits_i(s1_colb),
    .row_o(row1), .col_o(col1), .bank_o(bank1), .bg_o(bg1)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o       <= 1'b0;
      err_o        <= 1'b0;
      dimm_o       <= '0;
      rank_o       <= '0;
      rank_addr_o  <= '0;
      row_o        <= '0;
      col_o        <= '0;
      bank_o       <= '0;
      bank_group_o <= '0;
    end else begin
      done_o       <= s1_vld;
      err_o        <= s1_vld && !s1_hit;
      dimm_o       <= emit1 ? cr1[3:2] : 2'b00;
      rank_o       <= emit1 ? cr1[1:0] : 2'b00;
      rank_addr_o  <= emit1 ? ra1 : '0;
      row_o        <= emit1 ? row1 : '0;
      col_o        <= emit1 ? col1 : '0;
      bank_o       <= emit1 ? bank1 : 2'b00;
      bank_group_o <= emit1 ? bg1 : 2'b00;
    end
  end
endmodule

// File: rtl/rank_coord_dec_chk.sv
module rank_coord_dec_chk #(
  parameter int ADDR_W = 40
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              close_page_i,
  input logic [4:0]        row_bits_i,
  input logic              done_o,
  input logic              err_o,
  input logic [1:0]        dimm_o,
  input logic [1:0]        rank_o,
  input logic [ADDR_W-1:0] rank_addr_o,
  input logic [16:0]       row_o,
  input logic [10:0]       col_o,
  input logic [1:0]        bank_o,
  input logic [1:0]        bank_group_o
);
  logic coord_zero;
  assign coord_zero = (dimm_o == '0) && (rank_o == '0) && (rank_addr_o == '0) &&
                      (row_o == '0) && (col_o == '0) && (bank_o == '0) && (bank_group_o == '0);

  AST_DONE_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> ##2 done_o); // R3
  AST_DONE_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(req_valid_i, 2)); // R3
  AST_ERR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (done_o && coord_zero)); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (!err_o && coord_zero)); // R4
  AST_AUTOPRE_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o && $past(close_page_i, 2)) |-> col_o[10]); // R7
  AST_AUTOPRE_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o && !$past(close_page_i, 2)) |-> !col_o[10]); // R8
  AST_ROW_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> ((row_o >> $past(row_bits_i, 2)) == '0)); // R12
endmodule

bind rank_coord_dec rank_coord_dec_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .close_page_i(close_page_i), .row_bits_i(row_bits_i),
  .done_o(done_o), .err_o(err_o), .dimm_o(dimm_o), .rank_o(rank_o),
  .rank_addr_o(rank_addr_o), .row_o(row_o), .col_o(col_o),
  .bank_o(bank_o), .bank_group_o(bank_group_o)
);

// File: tb/rank_coord_dec_tb_top.sv
module rank_coord_dec_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        req = 1'b0;
  logic [39:0] caddr = '0;
  logic        cl = 1'b0, fg = 1'b0, bx = 1'b0;
  logic [4:0]  rb = 5'd17;
  logic [3:0]  cb = 4'd10;
  logic        done, err;
  logic [1:0]  dimm, rank, bank, bg;
  logic [39:0] raddr;
  logic [16:0] row;
  logic [10:0] col;

  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  rank_coord_dec dut_i (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .req_valid_i(req), .chan_addr_i(caddr), .close_page_i(cl), .fine_grain_i(fg),
    .bank_xor_i(bx), .row_bits_i(rb), .col_bits_i(cb),
    .done_o(done), .err_o(err), .dimm_o(dimm), .rank_o(rank), .rank_addr_o(raddr),
    .row_o(row), .col_o(col), .bank_o(bank), .bank_group_o(bg)
  );

  logic [31:0] rng_m [4];
  logic [3:0]  cr_m  [8][4];
  logic [13:0] off_m [8][4];

  int t_rc [17] = '{15, 16, 17, 18, 20, 21, 22, 28, 10, 11, 12, 13, 29, 30, 31, 32, 33};
  int t_ro [17] = '{14, 15, 16, 20, 28, 21, 22, 23, 24, 25, 26, 27, 29, 30, 31, 32, 33};
  int t_cc [10] = '{3, 4, 5, 14, 19, 23, 24, 25, 26, 27};
  int t_co [10] = '{3, 4, 5, 6, 7, 8, 9, 10, 11, 12};
  int t_cf [10] = '{3, 4, 5, 7, 8, 9, 10, 11, 12, 13};

  function automatic logic [77:0] model(logic [39:0] a);
    logic [63:0] lo, lim, q, w, ra, sh, rowv, colv;
    logic [1:0]  ba, bgv;
    logic [3:0]  crv;
    int sel, idx;
    sel = -1;
    lo = 0;
    for (int e = 0; e < 4; e++) begin
      lim = ({53'd0, rng_m[e][11:1]} << 29) | 64'h1FFF_FFFF;
      if (sel < 0 && rng_m[e][31] && {24'd0, a} >= lo && {24'd0, a} <= lim) sel = e;
      lo = lim;
    end
    if (sel < 0) return {2'b11, 76'd0};
    sh  = cl ? 64'd6 : 64'd13;
    w   = 64'd1 << rng_m[sel][29:28];
    q   = {24'd0, a} >> sh;
    idx = int'(q % w);
    ra  = ((q / w) << sh) | ({24'd0, a} & ((64'd1 << sh) - 1));
    ra  = (ra - ({50'd0, off_m[idx][sel]} << 26)) & 64'hFF_FFFF_FFFF;
    crv = cr_m[idx][sel];
    rowv = 0;
    for (int i = 0; i < 17; i++)
      if (i < int'(rb)) rowv |= ((ra >> (cl ? t_rc[i] : t_ro[i])) & 64'd1) << i;
    colv = 0;
    for (int i = 0; i < 10; i++)
      if (i < int'(cb)) colv |= ((ra >> (cl ? t_cc[i] : (fg ? t_cf[i] : t_co[i]))) & 64'd1) << i;
    if (cl) colv |= 64'd1 << 10;
    if (cl) begin
      ba  = {ra[9], ra[8]} ^ (bx ? {ra[28], ra[22]} : 2'b00);
      bgv = {ra[7], ra[6]};
    end else begin
      ba  = {ra[19], ra[18]} ^ (bx ? {ra[23], ra[22]} : 2'b00);
      bgv = {ra[17], fg ? ra[6] : ra[13]};
    end
    bgv = bgv ^ (bx ? {ra[21], ra[20]} : 2'b00);
    return {1'b1, 1'b0, crv[3:2], crv[1:0], ra[39:0], rowv[16:0], colv[10:0], ba, bgv};
  endfunction

  function automatic logic [77:0] outs();
    return {done, err, dimm, rank, raddr, row, col, bank, bg};
  endfunction

  task automatic check(string tag, logic [77:0] act, logic [77:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(bit c, bit f, bit x, int r, int k);
    @(negedge clk);
    cl = c; fg = f; bx = x; rb = 5'(r); cb = 4'(k);
  endtask

  task automatic wr_rng(int e, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {1'b0, 3'd0, 2'(e)}; wr_data = d;
    rng_m[e] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_ilv(int w, int e, int crv, int off);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {1'b1, 3'(w), 2'(e)};
    wr_data = (32'(crv) << 16) | (32'(off) << 2);
    cr_m[w][e] = 4'(crv); off_m[w][e] = 14'(off);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // one request; done must be low one cycle on and high two cycles on (R3)
  task automatic decode(string tag, logic [39:0] a);
    logic [77:0] exp;
    @(negedge clk);
    caddr = a; req = 1'b1;
    exp = model(a);
    @(negedge clk);
    req = 1'b0;
    check("R3 early", {77'd0, done}, 78'd0);
    @(negedge clk);
    check(tag, outs(), exp);
  endtask

  task automatic t_reset();
    check("R4 reset", outs(), 78'd0);
  endtask

  task automatic t_program();
    wr_rng(0, 32'h8000_0000 | (32'd7 << 1));                   // 1 way, up to 4G-1
    wr_rng(1, 32'd15 << 1);                                     // invalid
    wr_rng(2, 32'h8000_0000 | (32'd2 << 28) | (32'd31 << 1));   // 4 ways
    wr_rng(3, 32'h8000_0000 | (32'd1 << 28) | (32'd63 << 1));   // 2 ways
    wr_ilv(0, 0, 5, 0);
    for (int w = 0; w < 4; w++) wr_ilv(w, 2, 8 + w, 32'h20 + w);
    wr_ilv(0, 3, 2, 4);
    wr_ilv(1, 3, 13, 6);
  endtask

  task automatic t_close();
    set_cfg(1, 0, 0, 17, 10);
    decode("R5/R6/R7 close", 40'h0_1234_5678);
    decode("R5/R6/R7 close", 40'h0_FFFF_FFC0);
    decode("R5/R6/R7 close", 40'h7_ABCD_1234);
    decode("R5/R6/R7 close", 40'h5_5555_5555);
  endtask

  task automatic t_open();
    set_cfg(0, 0, 0, 17, 10);
    decode("R5/R6/R8 open", 40'h0_1234_5678);
    decode("R5/R6/R8 open", 40'h7_ABCD_1234);
    decode("R5/R6/R8 open", 40'h4_AAAA_AAAA);
  endtask

  task automatic t_fine();
    set_cfg(0, 1, 0, 17, 10);
    decode("R9 fine", 40'h0_0000_3FC0);
    decode("R9 fine", 40'h0_0000_0040);
    decode("R9 fine", 40'h6_F0F0_2468);
  endtask

  task automatic t_bank();
    set_cfg(1, 0, 0, 17, 10);
    decode("R10 bank close", 40'h0_0000_0300);
    decode("R10 bank close", 40'h0_0000_00C0);
    set_cfg(0, 0, 0, 17, 10);
    decode("R10 bank open", 40'h0_000C_0000);
    decode("R10 bank open", 40'h0_0002_2000);
  endtask

  task automatic t_xor();
    set_cfg(1, 0, 1, 17, 10);
    decode("R11 xor close", 40'h0_1040_0000);
    decode("R11 xor close", 40'h0_0030_0000);
    set_cfg(0, 0, 1, 17, 10);
    decode("R11 xor open", 40'h0_00C0_0000);
    decode("R11 xor open", 40'h0_0034_0000);
  endtask

  task automatic t_interleave();
    set_cfg(1, 0, 0, 17, 10);
    for (int k = 0; k < 4; k++) decode("R5/R6 ways close", 40'h2_0000_0000 + 40'(k) * 40'h40);
    set_cfg(0, 0, 0, 17, 10);
    for (int k = 0; k < 4; k++) decode("R5/R6 ways open", 40'h2_4000_0000 + 40'(k) * 40'h2000);
  endtask

  task automatic t_range();
    set_cfg(1, 0, 0, 17, 10);
    decode("R1 entry0 top", 40'h0_FFFF_FFFF);
    decode("R1/R4 invalid gap", 40'h1_0000_0000);
    decode("R2/R4 below bound", 40'h1_FFFF_FFFE);
    decode("R2 inclusive bound", 40'h1_FFFF_FFFF);
    decode("R1/R2 shared limit", 40'h3_FFFF_FFFF);
    decode("R1 entry3 top", 40'h7_FFFF_FFFF);
    decode("R4 above all", 40'h8_0000_0000);
  endtask

  task automatic t_rowmask();
    set_cfg(1, 0, 0, 12, 10);
    decode("R12 rows12", 40'h3_FFFF_FFC0);
    set_cfg(0, 0, 0, 14, 10);
    decode("R12 rows14", 40'h7_FFFF_FFFF);
  endtask

  task automatic t_sweep();
    logic [63:0] x = 64'h9E37_79B9_7F4A_7C15;
    for (int n = 0; n < 48; n++) begin
      x ^= x << 13; x ^= x >> 7; x ^= x << 17;
      set_cfg(x[40], x[41], x[42], 12 + int'(x[45:43] % 6), 10);
      decode("R1/R5/R6/R7/R8/R9/R10/R11/R12 sweep", 40'(x % 64'h9_0000_0000));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int e = 0; e < 4; e++) begin
      rng_m[e] = '0;
      for (int w = 0; w < 8; w++) begin cr_m[w][e] = '0; off_m[w][e] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_close();
    t_open();
    t_fine();
    t_bank();
    t_xor();
    t_interleave();
    t_range();
    t_rowmask();
    t_sweep();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule